// File: doc/BRIEF.md
# Transmit buffer selection arbiter

This block chooses which of several transmit buffers holds the next frame to send. It then validates that buffer by reading its frame-format word, both timestamp words and its identifier word from a buffer RAM with synchronous reads. Each word goes into a capture register. The identifier therefore sits in a register before transmission starts. The protocol engine can lock the selection and preload its shift register with the base identifier in the same clock cycle, with no wait on RAM latency.

The arbiter drives the RAM address with its own pointer until the lock arrives. While the selection is locked, the index and all captured words are frozen, and the arbiter issues no RAM reads. An unlock pulse from the protocol engine returns the machine to idle, and a new selection round starts from there.

The block has no streaming interface. The ready flags, priorities, lock and unlock inputs are plain level or pulse controls, and the outputs are plain levels. There is no back-pressure anywhere: the RAM always returns data one cycle after a read, and the protocol engine samples the outputs whenever it chooses.

Top module: `txsel_arbiter`

## Requirements
- R1: While reset is asserted, sel_valid, locked and ram_rd_en are 0 and all four capture outputs are 0.
- R2: When no buffer is ready, the block stays idle: ram_rd_en stays 0 and sel_valid stays 0.
- R3: Among ready buffers the one with the largest priority value is selected. Buffer i uses priority field buf_prio[i*PRIO_W +: PRIO_W]. When priorities are equal, the lowest index wins.
- R4: Validation issues exactly four reads at ram_addr = {index, offset}, with offset in the low 2 bits, in the order 0 (format), 1 (timestamp low), 2 (timestamp high), 3 (identifier). Each read waits one cycle for its data. From idle, sel_valid rises on the 9th rising edge after a buffer becomes ready.
- R5: Once sel_valid is 1, cap_fmt, cap_ts_lo, cap_ts_hi and cap_id equal the RAM words at offsets 0, 1, 2 and 3 of the buffer given by sel_idx.
- R6: While validated with an unchanged winner, the selection holds, sel_valid stays 1 and no RAM read is issued.
- R7: If the winning buffer changes during validation or while validated, validation restarts from offset 0 for the new buffer. sel_valid rises 9 edges after the change.
- R8: If no buffer remains ready while validated and not locked, sel_valid is 0 one cycle later.
- R9: lock_req while validated sets locked on the next cycle. While locked, sel_idx and the captured words do not change, whatever happens to the ready flags, and no RAM read is issued.
- R10: lock_req while sel_valid is 0 is ignored, and locked stays 0.
- R11: unlock_req while locked clears locked and sel_valid on the next cycle. Selection then restarts from idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| buf_ready | input | NBUF | Per-buffer ready flags |
| buf_prio | input | NBUF*PRIO_W | Packed per-buffer priorities |
| lock_req | input | 1 | Lock pulse from protocol engine |
| unlock_req | input | 1 | Unlock pulse from protocol engine |
| ram_rdata | input | DW | Buffer RAM read data, one cycle after the read |
| ram_rd_en | output | 1 | Buffer RAM read enable |
| ram_addr | output | IDX_W+2 | Buffer RAM address {index, word offset} |
| sel_idx | output | IDX_W | Selected buffer index |
| sel_valid | output | 1 | Selected buffer validated (or locked) |
| locked | output | 1 | Selection locked by protocol engine |
| cap_fmt | output | DW | Captured frame-format word |
| cap_ts_lo | output | DW | Captured timestamp low word |
| cap_ts_hi | output | DW | Captured timestamp high word |
| cap_id | output | DW | Captured identifier word |

## Verification
A wrong sequencer state shows up at the ports within one RAM round trip. A stray or missing read shows on ram_rd_en and ram_addr in the same cycle. A skipped or reordered word puts a wrong value into a capture output. A mistimed transition shifts the rise of sel_valid away from the 9th edge. A bad lock state shows up one cycle after the lock or unlock pulse, either as locked not changing or as captured words drifting while the ready flags change.

// File: rtl/txsel_pkg.sv
package txsel_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_RD_FMT = 3'd1,
    ST_RD_TSL = 3'd2,
    ST_RD_TSH = 3'd3,
    ST_SEL_ID = 3'd4,
    ST_VALID  = 3'd5,
    ST_LOCKED = 3'd6
  } seq_state_e;

  localparam int unsigned NWORDS = 4;
  localparam int unsigned OFS_W  = 2;
  localparam logic [OFS_W-1:0] OFS_FMT = 2'd0;
  localparam logic [OFS_W-1:0] OFS_TSL = 2'd1;
  localparam logic [OFS_W-1:0] OFS_TSH = 2'd2;
  localparam logic [OFS_W-1:0] OFS_ID  = 2'd3;
endpackage

// File: rtl/txsel_prio_pick.sv
module txsel_prio_pick #(
  parameter int unsigned NBUF   = 4,
  parameter int unsigned PRIO_W = 3,
  localparam int unsigned IDX_W = $clog2(NBUF)
) (
  input  logic [NBUF-1:0]        ready,
  input  logic [NBUF*PRIO_W-1:0] prio,
  output logic                   win_valid,
  output logic [IDX_W-1:0]       win_idx
);
  logic [PRIO_W-1:0] best;

  // Scan from the top index down; ">=" lets a lower index take over on a tie.
  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    best      = '0;
    for (int i = NBUF - 1; i >= 0; i--) begin
      if (ready[i] && (!win_valid || prio[i*PRIO_W +: PRIO_W] >= best)) begin
        win_valid = 1'b1;
        win_idx   = IDX_W'(i);
        best      = prio[i*PRIO_W +: PRIO_W];
      end
    end
    // R3
    win_ready_chk: assert (!win_valid || ready[win_idx]);
    // R2
    win_any_chk: assert (win_valid == (|ready));
  end
endmodule

// File: rtl/txsel_seq.sv
module txsel_seq
  import txsel_pkg::*;
#(
  parameter int unsigned NBUF = 4,
  localparam int unsigned IDX_W  = $clog2(NBUF),
  localparam int unsigned ADDR_W = IDX_W + OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              win_valid,
  input  logic [IDX_W-1:0]  win_idx,
  input  logic              lock_req,
  input  logic              unlock_req,
  output logic [IDX_W-1:0]  sel_idx,
  output logic              sel_valid,
  output logic              locked,
  output logic              ram_rd_en,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [NWORDS-1:0] cap_en
);
  seq_state_e       state;
  logic             phase;   // 0: read issued this cycle, 1: data on ram_rdata
  logic [OFS_W-1:0] rd_ofs;
  logic             is_rd;
  seq_state_e       rd_next;

  always_comb begin
    is_rd   = 1'b1;
    rd_ofs  = OFS_FMT;
    rd_next = ST_RD_TSL;
    case (state)
      ST_RD_FMT: begin rd_ofs = OFS_FMT; rd_next = ST_RD_TSL; end
      ST_RD_TSL: begin rd_ofs = OFS_TSL; rd_next = ST_RD_TSH; end
      ST_RD_TSH: begin rd_ofs = OFS_TSH; rd_next = ST_SEL_ID; end
      ST_SEL_ID: begin rd_ofs = OFS_ID;  rd_next = ST_VALID;  end
      default:   is_rd = 1'b0;
    endcase
  end

  assign ram_rd_en = is_rd && !phase;
  assign ram_addr  = {sel_idx, rd_ofs};
  assign cap_en    = (is_rd && phase) ? (NWORDS'(1) << rd_ofs) : '0;
  assign sel_valid = (state == ST_VALID) || (state == ST_LOCKED);
  assign locked    = (state == ST_LOCKED);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      phase   <= 1'b0;
      sel_idx <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          phase <= 1'b0;
          if (win_valid) begin
            sel_idx <= win_idx;
            state   <= ST_RD_FMT;
          end
        end
        ST_RD_FMT, ST_RD_TSL, ST_RD_TSH, ST_SEL_ID: begin
          if (!win_valid) begin
            state <= ST_IDLE;
            phase <= 1'b0;
          end else if (win_idx != sel_idx) begin
            sel_idx <= win_idx;
            state   <= ST_RD_FMT;
            phase   <= 1'b0;
          end else if (!phase) begin
            phase <= 1'b1;
          end else begin
            phase <= 1'b0;
            state <= rd_next;
          end
        end
        ST_VALID: begin
          if (lock_req) begin
            state <= ST_LOCKED;
          end else if (!win_valid) begin
            state <= ST_IDLE;
          end else if (win_idx != sel_idx) begin
            sel_idx <= win_idx;
            state   <= ST_RD_FMT;
            phase   <= 1'b0;
          end
        end
        ST_LOCKED: if (unlock_req) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R6
  rd_unsel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_rd_en |-> !sel_valid);
  // R10
  lock_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_valid && lock_req) |=> !locked);
  // R9
  lock_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_valid && !locked && lock_req) |=> locked);
  // R11
  unlock_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && unlock_req) |=> (!sel_valid && !locked));
  // R8
  drop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_valid && !locked && !lock_req && !win_valid) |=> !sel_valid);
endmodule

// File: rtl/txsel_capture_bank.sv
module txsel_capture_bank #(
  parameter int unsigned NW = 4,
  parameter int unsigned DW = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NW-1:0]        cap_en,
  input  logic [DW-1:0]        wdata,
  output logic [NW-1:0][DW-1:0] words
);
  for (genvar g = 0; g < NW; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n)        words[g] <= '0;
      else if (cap_en[g]) words[g] <= wdata;
    end
  end

  // R5
  cap_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cap_en));
endmodule

// File: rtl/txsel_arbiter.sv
module txsel_arbiter
  import txsel_pkg::*;
#(
  parameter int unsigned NBUF   = 4,
  parameter int unsigned PRIO_W = 3,
  parameter int unsigned DW     = 32,
  localparam int unsigned IDX_W  = $clog2(NBUF),
  localparam int unsigned ADDR_W = IDX_W + OFS_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NBUF-1:0]        buf_ready,
  input  logic [NBUF*PRIO_W-1:0] buf_prio,
  input  logic                   lock_req,
  input  logic                   unlock_req,
  input  logic [DW-1:0]          ram_rdata,
  output logic                   ram_rd_en,
  output logic [ADDR_W-1:0]      ram_addr,
  output logic [IDX_W-1:0]       sel_idx,
  output logic                   sel_valid,
  output logic                   locked,
  output logic [DW-1:0]          cap_fmt,
  output logic [DW-1:0]          cap_ts_lo,
  output logic [DW-1:0]          cap_ts_hi,
  output logic [DW-1:0]          cap_id
);
  logic                     win_valid;
  logic [IDX_W-1:0]         win_idx;
  logic [NWORDS-1:0]        cap_en;
  logic [NWORDS-1:0][DW-1:0] words;

  txsel_prio_pick #(.NBUF(NBUF), .PRIO_W(PRIO_W)) u_pick (
    .ready(buf_ready), .prio(buf_prio),
    .win_valid(win_valid), .win_idx(win_idx)
  );

  txsel_seq #(.NBUF(NBUF)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .win_valid(win_valid), .win_idx(win_idx),
    .lock_req(lock_req), .unlock_req(unlock_req),
    .sel_idx(sel_idx), .sel_valid(sel_valid), .locked(locked),
    .ram_rd_en(ram_rd_en), .ram_addr(ram_addr), .cap_en(cap_en)
  );

  txsel_capture_bank #(.NW(NWORDS), .DW(DW)) u_cap (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en),
    .wdata(ram_rdata), .words(words)
  );

  assign cap_fmt   = words[OFS_FMT];
  assign cap_ts_lo = words[OFS_TSL];
  assign cap_ts_hi = words[OFS_TSH];
  assign cap_id    = words[OFS_ID];

  // R9
  lock_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !unlock_req) |=> ($stable(sel_idx) && $stable(cap_id) &&
                                 $stable(cap_fmt) && !ram_rd_en));
endmodule

// File: tb/tb_txsel_arbiter.sv
module tb_txsel_arbiter;
  localparam int NBUF = 4;
  localparam int PW   = 3;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [3:0]     buf_ready = '0;
  logic [11:0]    buf_prio = '0;
  logic           lock_req = 1'b0, unlock_req = 1'b0;
  logic [31:0]    ram_rdata = '0;
  logic           ram_rd_en, sel_valid, locked;
  logic [3:0]     ram_addr;
  logic [1:0]     sel_idx;
  logic [31:0]    cap_fmt, cap_ts_lo, cap_ts_hi, cap_id;

  int n_chk = 0, n_bad = 0, rd_cnt = 0;
  logic [3:0] rd_log [0:15];
  bit done = 0;

  always #10 clk = ~clk;

  txsel_arbiter #(.NBUF(NBUF), .PRIO_W(PW), .DW(32)) dut (
    .clk(clk), .rst_n(rst_n), .buf_ready(buf_ready), .buf_prio(buf_prio),
    .lock_req(lock_req), .unlock_req(unlock_req), .ram_rdata(ram_rdata),
    .ram_rd_en(ram_rd_en), .ram_addr(ram_addr), .sel_idx(sel_idx),
    .sel_valid(sel_valid), .locked(locked), .cap_fmt(cap_fmt),
    .cap_ts_lo(cap_ts_lo), .cap_ts_hi(cap_ts_hi), .cap_id(cap_id)
  );

  function automatic logic [31:0] wval(int idx, int ofs);
    return {8'hA5, 4'(idx), 4'(ofs), 16'(idx * 257 + ofs * 17 + 1)};
  endfunction

  always @(posedge clk) begin
    if (ram_rd_en) begin
      ram_rdata <= wval(int'(ram_addr[3:2]), int'(ram_addr[1:0]));
      if (rst_n) begin
        rd_log[rd_cnt[3:0]] <= ram_addr;
        rd_cnt <= rd_cnt + 1;
      end
    end
  end

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic set_prio(int p0, int p1, int p2, int p3);
    buf_prio = {3'(p3), 3'(p2), 3'(p1), 3'(p0)};
  endtask

  task automatic wait_valid(output int cyc);
    cyc = 0;
    while (!sel_valid && cyc < 60) begin @(negedge clk); cyc++; end
  endtask

  task automatic check_caps(int idx, string req);
    chk(sel_idx == 2'(idx), req, "sel_idx", sel_idx, idx);
    chk(cap_fmt == wval(idx, 0), req, "cap_fmt", cap_fmt, wval(idx, 0));
    chk(cap_ts_lo == wval(idx, 1), req, "cap_ts_lo", cap_ts_lo, wval(idx, 1));
    chk(cap_ts_hi == wval(idx, 2), req, "cap_ts_hi", cap_ts_hi, wval(idx, 2));
    chk(cap_id == wval(idx, 3), req, "cap_id", cap_id, wval(idx, 3));
  endtask

  task automatic go_idle();
    buf_ready = '0;
    @(negedge clk);
    // R8: one cycle after the last ready flag drops
    chk(!sel_valid, "R8", "sel_valid after drop", sel_valid, 0);
    @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    // R1
    chk(!sel_valid && !locked && !ram_rd_en, "R1", "ctl in reset",
        {sel_valid, locked, ram_rd_en}, 0);
    chk(cap_id == 0 && cap_fmt == 0, "R1", "caps in reset", cap_id, 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_idle();
    int c0 = rd_cnt;
    buf_ready = '0;
    repeat (10) @(negedge clk);
    // R2
    chk(rd_cnt == c0 && !sel_valid, "R2", "reads while idle", rd_cnt - c0, 0);
  endtask

  task automatic t_single();
    int cyc, c0;
    c0 = rd_cnt;
    set_prio(1, 1, 2, 1);
    buf_ready = 4'b0100;
    wait_valid(cyc);
    // R4
    chk(cyc == 9, "R4", "cycles to valid", cyc, 9);
    chk(rd_cnt - c0 == 4, "R4", "read count", rd_cnt - c0, 4);
    for (int k = 0; k < 4; k++)
      chk(rd_log[4'(c0 + k)] == {2'd2, 2'(k)}, "R4", "read addr",
          rd_log[4'(c0 + k)], {2'd2, 2'(k)});
    // R5
    check_caps(2, "R5");
    c0 = rd_cnt;
    repeat (10) @(negedge clk);
    // R6
    chk(rd_cnt == c0 && sel_valid && sel_idx == 2, "R6", "hold validated",
        rd_cnt - c0, 0);
    go_idle();
  endtask

  task automatic t_priority();
    int cyc;
    set_prio(1, 5, 3, 5);
    buf_ready = 4'b1111;
    wait_valid(cyc);
    // R3: tie between 1 and 3 at priority 5 goes to index 1
    chk(sel_idx == 1, "R3", "highest prio, tie low idx", sel_idx, 1);
    check_caps(1, "R3");
    go_idle();
    set_prio(7, 0, 2, 2);
    buf_ready = 4'b1100;
    wait_valid(cyc);
    // R3: equal priorities, lowest index wins
    chk(sel_idx == 2, "R3", "tie", sel_idx, 2);
    go_idle();
  endtask

  task automatic t_change();
    int cyc;
    set_prio(1, 4, 6, 0);
    buf_ready = 4'b0001;
    repeat (3) @(negedge clk);
    buf_ready = 4'b0011;
    wait_valid(cyc);
    // R7: change mid-validation restarts
    chk(cyc == 9, "R7", "cycles after mid change", cyc, 9);
    check_caps(1, "R7");
    buf_ready = 4'b0111;
    @(negedge clk);
    chk(!sel_valid, "R7", "valid drops on change", sel_valid, 0);
    wait_valid(cyc);
    chk(cyc == 8, "R7", "revalidate cycles", cyc, 8);
    check_caps(2, "R7");
  endtask

  task automatic t_lock();
    int cyc, c0;
    lock_req = 1'b1;
    @(negedge clk);
    lock_req = 1'b0;
    // R9
    chk(locked && sel_valid, "R9", "locked after lock", locked, 1);
    c0 = rd_cnt;
    set_prio(1, 4, 6, 7);
    buf_ready = 4'b1000;
    repeat (10) @(negedge clk);
    chk(locked && rd_cnt == c0, "R9", "no reads while locked", rd_cnt - c0, 0);
    check_caps(2, "R9");
    unlock_req = 1'b1;
    @(negedge clk);
    unlock_req = 1'b0;
    // R11
    chk(!locked && !sel_valid, "R11", "unlock clears", {locked, sel_valid}, 0);
    wait_valid(cyc);
    chk(cyc == 9, "R11", "reselect cycles", cyc, 9);
    check_caps(3, "R11");
    go_idle();
  endtask

  task automatic t_lock_ignored();
    int cyc;
    lock_req = 1'b1;
    @(negedge clk);
    lock_req = 1'b0;
    // R10: lock while idle
    chk(!locked, "R10", "lock in idle", locked, 0);
    set_prio(3, 0, 0, 0);
    buf_ready = 4'b0001;
    repeat (2) @(negedge clk);
    lock_req = 1'b1;
    @(negedge clk);
    lock_req = 1'b0;
    chk(!locked, "R10", "lock mid-validation", locked, 0);
    wait_valid(cyc);
    chk(sel_valid && !locked, "R10", "validated, not locked", locked, 0);
    check_caps(0, "R10");
    go_idle();
  endtask

  initial begin
    t_reset();
    t_idle();
    t_single();
    t_priority();
    t_change();
    t_lock();
    t_lock_ignored();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule